// File: doc/BRIEF.md
# Flash self-programming command controller

This block holds the command register through which a processor rewrites its own program flash. Software writes a command byte that sets an enable bit and at most one function bit. The write arms the command for a short window of clock edges. A store strobe from the instruction decoder inside that window runs the armed action. The actions are: fill one word of a temporary page buffer, erase a page, program a page from the buffer, set the boot lock byte, or release the read-while-write section. For the two read modes, a load strobe inside a shorter window returns the lock byte, the fuse byte or a signature byte.

Erase and program go to the flash array through a level request held until a one-cycle done pulse. While such an operation runs, the command register stays set and further writes are ignored. Two outputs follow the target page. One flags the read-while-write section as busy. The other halts the processor when the page lies in the section that cannot be read during programming. The page buffer returns to all ones after a page program and when a load is abandoned, so unloaded words program as erased.

The control sits in a three-state machine. IDLE moves to ARMED on **arm** (a valid command write). ARMED has four exits. **Re-arm** is a new valid write, which restarts the window. **Disarm** is a write with bit 0 clear, which goes to IDLE. **Expire** is the window running out, which goes to IDLE. **Execute** is a store strobe for a single-cycle action, which goes to IDLE. A store strobe for erase or program is **launch**, from ARMED to BUSY. BUSY returns to IDLE on **complete**, the flash done pulse.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, no flash request is raised, halt and section-busy are low, no load result is valid, and the lock byte is 0xFF.
- R2: A command write arms the controller only when bit 0 is 1 and bits 7 and 6 are 0. The status byte then reads bit 0 plus the decoded function bit. A store strobe is accepted on any of the four clock edges after the write edge. With no strobe, the status byte reads 0x00 after the fourth edge and a later strobe does nothing. A write with bit 0 clear while armed disarms at once.
- R3: With no function bit set, a store strobe writes {data_hi, data_lo} into buffer word z_addr[3:1]. Bit 0 of z_addr is ignored. The status byte then clears.
- R4: Bit 1 selects page erase. The store strobe raises fl_req with fl_op=0 and fl_page=z_addr[15:4]. The data bytes are ignored.
- R5: Bit 2 selects page program, with fl_op=1. The array reads the buffer through fl_buf_idx/fl_buf_word. After completion every buffer word reads 0xFFFF.
- R6: During an erase or program, status bit 0 and the function bit stay set, fl_req stays high, and command writes are ignored. The edge that samples fl_done clears the status byte and drops fl_req.
- R7: An erase or program of a page below NRWW_START_PAGE (3584) sets rww_busy, which also reads as status bit 6.
- R8: An erase or program of a page at or above NRWW_START_PAGE raises cpu_halt for the whole operation. cpu_halt is low again after completion.
- R9: Bit 4 selects section re-enable. Its store strobe clears rww_busy.
- R10: Arming section re-enable while the buffer holds loaded words returns every buffer word to 0xFFFF.
- R11: Bit 3 selects lock set. Its store strobe writes data_lo into lock_bits. data_hi and z_addr are ignored.
- R12: With lock set or signature read (bit 5) armed, a load strobe on one of the first three edges after the arm write gives lpm_valid one cycle later. Under lock set, lpm_data carries lock_bits when z_addr[0]=0 and fuse_bits when it is 1. Under signature read, lpm_data carries signature byte z_addr[1:0] (0x1E, 0x3C, 0x5A, 0xFF). A load strobe on the fourth edge is not served. A store strobe under signature read has no effect.
- R13: When several function bits are set, the command taken is the first present in this order: erase, program, lock set, re-enable, signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Status byte (enable, function bits, bit 6 section busy) |
| spm_strobe | input | 1 | Store-program strobe from the decoder |
| lpm_strobe | input | 1 | Load-program strobe from the decoder |
| z_addr | input | ZW | Byte address |
| data_lo | input | 8 | Low data byte |
| data_hi | input | 8 | High data byte |
| fuse_bits | input | 8 | Fuse byte for read-back |
| lpm_valid | output | 1 | Load result valid |
| lpm_data | output | 8 | Load result |
| lock_bits | output | 8 | Boot lock byte |
| fl_req | output | 1 | Flash operation request |
| fl_op | output | 1 | 0 erase, 1 program |
| fl_page | output | PGW | Target page |
| fl_done | input | 1 | One-cycle completion pulse |
| fl_buf_idx | input | WB | Buffer word index read by the array |
| fl_buf_word | output | 16 | Buffer word at fl_buf_idx |
| rww_busy | output | 1 | Read-while-write section blocked |
| cpu_halt | output | 1 | Processor halt request |

## Verification
The assertions assume that fl_done pulses only while fl_req is high, and that the decoder never raises a store strobe and a load strobe in the same cycle as a command write. The bench responder emits a single done pulse a fixed latency after each request. The stimulus tasks drive one strobe or one write per cycle, with idle cycles between scenarios so each window has closed before the next one opens.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
package fsp_pkg;
    localparam int CB_EN      = 0;
    localparam int CB_ERASE   = 1;
    localparam int CB_WRITE   = 2;
    localparam int CB_LOCK    = 3;
    localparam int CB_REEN    = 4;
    localparam int CB_SIG     = 5;
    localparam int SB_RWWBUSY = 6;

    typedef enum logic [2:0] {
        OP_NONE, OP_LOAD, OP_ERASE, OP_WRITE, OP_LOCK, OP_REEN, OP_SIG
    } cmd_e;

    typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_BUSY} state_e;

    // f holds command bits 5..1; fixed priority R13
    function automatic cmd_e decode_cmd(input logic [4:0] f);
        if (f[0]) return OP_ERASE;
        if (f[1]) return OP_WRITE;
        if (f[2]) return OP_LOCK;
        if (f[3]) return OP_REEN;
        if (f[4]) return OP_SIG;
        return OP_LOAD;
    endfunction

    function automatic logic [7:0] status_bits(input cmd_e c, input logic en, input logic busy);
        logic [7:0] s;
        s = '0;
        s[CB_EN] = en;
        case (c)
            OP_ERASE: s[CB_ERASE] = 1'b1;
            OP_WRITE: s[CB_WRITE] = 1'b1;
            OP_LOCK:  s[CB_LOCK]  = 1'b1;
            OP_REEN:  s[CB_REEN]  = 1'b1;
            OP_SIG:   s[CB_SIG]   = 1'b1;
            default:  ;
        endcase
        s[SB_RWWBUSY] = busy;
        return s;
    endfunction
endpackage

// File: rtl/fsp_page_buf.sv
`timescale 1ns/1ps
module fsp_page_buf #(
    parameter int WORDS = 8,
    localparam int WB = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WB-1:0] wr_idx,
    input  logic [15:0]   wr_data,
    input  logic          fill,
    input  logic [WB-1:0] rd_idx,
    output logic [15:0]   rd_data
);
    logic [15:0] mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n || fill)
                mem[i] <= 16'hFFFF;
            else if (wr_en && (wr_idx == WB'(i)))
                mem[i] <= wr_data;
        end
    end

    always_comb rd_data = mem[rd_idx];

    // a refill and a word load never share a cycle
    assert_fill_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill && wr_en));
endmodule

// File: rtl/fsp_cmd_fsm.sv
`timescale 1ns/1ps
module fsp_cmd_fsm
    import fsp_pkg::*;
#(
    parameter int PGW             = 12,
    parameter int ARM_WIN         = 4,
    parameter int RD_WIN          = 3,
    parameter int NRWW_START_PAGE = 3584,
    localparam int CW = (ARM_WIN > 2) ? $clog2(ARM_WIN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_we,
    input  logic [7:0]     cmd_wdata,
    input  logic           spm,
    input  logic           lpm,
    input  logic [PGW-1:0] page,
    input  logic           fl_done,
    output logic [7:0]     status,
    output logic           buf_wr,
    output logic           buf_fill,
    output logic           lock_we,
    output logic           rd_grant,
    output logic           rd_is_sig,
    output logic           fl_req,
    output logic           fl_op,
    output logic [PGW-1:0] fl_page,
    output logic           rww_busy,
    output logic           cpu_halt
);
    state_e         st, st_n;
    cmd_e           cmd, cmd_n, dec;
    logic [CW-1:0]  cnt, cnt_n;
    logic           loaded, rww_q, halt_q, op_q;
    logic [PGW-1:0] page_q;
    logic           wen, in_nrww, start_op, reen_go;

    assign dec     = decode_cmd(cmd_wdata[CB_SIG:CB_ERASE]);
    assign wen     = cmd_wdata[CB_EN] && (cmd_wdata[7:6] == 2'b00);
    assign in_nrww = page >= PGW'(NRWW_START_PAGE);

    // next state and strobes
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        cmd_n    = cmd;
        buf_wr   = 1'b0;
        buf_fill = 1'b0;
        lock_we  = 1'b0;
        start_op = 1'b0;
        reen_go  = 1'b0;
        rd_grant = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (cmd_we && wen) begin            // arm
                    st_n     = ST_ARMED;
                    cnt_n    = '0;
                    cmd_n    = dec;
                    buf_fill = (dec == OP_REEN) && loaded;
                end
            end
            ST_ARMED: begin
                if (cmd_we) begin
                    if (wen) begin                  // re-arm
                        cnt_n    = '0;
                        cmd_n    = dec;
                        buf_fill = (dec == OP_REEN) && loaded;
                    end else begin                  // disarm
                        st_n  = ST_IDLE;
                        cmd_n = OP_NONE;
                    end
                end else begin
                    rd_grant = lpm && (cmd == OP_LOCK || cmd == OP_SIG)
                               && (int'(cnt) < RD_WIN);
                    if (spm && cmd != OP_SIG) begin
                        unique case (cmd)
                            OP_LOAD:            buf_wr   = 1'b1;
                            OP_ERASE, OP_WRITE: start_op = 1'b1;
                            OP_LOCK:            lock_we  = 1'b1;
                            OP_REEN:            reen_go  = 1'b1;
                            default:            ;
                        endcase
                        if (start_op) begin         // launch
                            st_n = ST_BUSY;
                        end else begin              // execute
                            st_n  = ST_IDLE;
                            cmd_n = OP_NONE;
                        end
                    end else if (cnt == CW'(ARM_WIN - 1)) begin  // expire
                        st_n  = ST_IDLE;
                        cmd_n = OP_NONE;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (fl_done) begin                  // complete
                    st_n     = ST_IDLE;
                    cmd_n    = OP_NONE;
                    buf_fill = (cmd == OP_WRITE);
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            cmd    <= OP_NONE;
            loaded <= 1'b0;
            rww_q  <= 1'b0;
            halt_q <= 1'b0;
            op_q   <= 1'b0;
            page_q <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            cmd <= cmd_n;
            if (buf_fill)    loaded <= 1'b0;
            else if (buf_wr) loaded <= 1'b1;
            if (start_op) begin
                page_q <= page;
                op_q   <= (cmd == OP_WRITE);
                if (in_nrww) halt_q <= 1'b1;
                else         rww_q  <= 1'b1;
            end else begin
                if (reen_go)                  rww_q  <= 1'b0;
                if (st == ST_BUSY && fl_done) halt_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        status    = status_bits(cmd, st != ST_IDLE, rww_q);
        fl_req    = (st == ST_BUSY);
        fl_op     = op_q;
        fl_page   = page_q;
        rww_busy  = rww_q;
        cpu_halt  = halt_q;
        rd_is_sig = (cmd == OP_SIG);
    end

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_done) |=> fl_req);
    assert_busy_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && !fl_done) |=> (status == $past(status)));
    assert_req_from_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) |-> $past(spm));
    assert_halt_in_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> fl_req);
    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rww_busy) |-> $rose(fl_req));
endmodule

// File: rtl/flash_selfprog_ctrl.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl #(
    parameter int          ZW              = 16,
    parameter int          PAGE_WORDS      = 8,
    parameter int          ARM_WIN         = 4,
    parameter int          RD_WIN          = 3,
    parameter int          NRWW_START_PAGE = 3584,
    parameter logic [7:0]  LOCK_RESET      = 8'hFF,
    parameter logic [31:0] SIG_BYTES       = 32'hFF5A_3C1E,
    localparam int WB  = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1,
    localparam int PGW = ZW - WB - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_we,
    input  logic [7:0]     cmd_wdata,
    output logic [7:0]     cmd_rdata,
    input  logic           spm_strobe,
    input  logic           lpm_strobe,
    input  logic [ZW-1:0]  z_addr,
    input  logic [7:0]     data_lo,
    input  logic [7:0]     data_hi,
    input  logic [7:0]     fuse_bits,
    output logic           lpm_valid,
    output logic [7:0]     lpm_data,
    output logic [7:0]     lock_bits,
    output logic           fl_req,
    output logic           fl_op,
    output logic [PGW-1:0] fl_page,
    input  logic           fl_done,
    input  logic [WB-1:0]  fl_buf_idx,
    output logic [15:0]    fl_buf_word,
    output logic           rww_busy,
    output logic           cpu_halt
);
    logic       buf_wr, buf_fill, lock_we, rd_grant, rd_is_sig;
    logic [7:0] lock_q, sig_sel, rd_sel;

    fsp_cmd_fsm #(
        .PGW(PGW), .ARM_WIN(ARM_WIN), .RD_WIN(RD_WIN),
        .NRWW_START_PAGE(NRWW_START_PAGE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .spm(spm_strobe), .lpm(lpm_strobe), .page(z_addr[ZW-1:WB+1]),
        .fl_done(fl_done), .status(cmd_rdata), .buf_wr(buf_wr),
        .buf_fill(buf_fill), .lock_we(lock_we), .rd_grant(rd_grant),
        .rd_is_sig(rd_is_sig), .fl_req(fl_req), .fl_op(fl_op),
        .fl_page(fl_page), .rww_busy(rww_busy), .cpu_halt(cpu_halt)
    );

    fsp_page_buf #(.WORDS(PAGE_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_wr), .wr_idx(z_addr[WB:1]),
        .wr_data({data_hi, data_lo}), .fill(buf_fill),
        .rd_idx(fl_buf_idx), .rd_data(fl_buf_word)
    );

    always_comb begin
        sig_sel = SIG_BYTES[{z_addr[1:0], 3'b000} +: 8];
        rd_sel  = rd_is_sig ? sig_sel : (z_addr[0] ? fuse_bits : lock_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= LOCK_RESET;
            lpm_valid <= 1'b0;
            lpm_data  <= '0;
        end else begin
            if (lock_we)  lock_q   <= data_lo;
            lpm_valid <= rd_grant;
            if (rd_grant) lpm_data <= rd_sel;
        end
    end

    assign lock_bits = lock_q;

    assert_lpm_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_valid |-> $past(lpm_strobe));
    assert_lock_by_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bits != $past(lock_bits)) |-> $past(spm_strobe));
endmodule

// File: tb/tb_flash_selfprog_ctrl.sv
`timescale 1ns/1ps
module tb_flash_selfprog_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cmd_we = 0, spm_strobe = 0, lpm_strobe = 0, fl_done = 0;
    logic [7:0]  cmd_wdata = 0, data_lo = 0, data_hi = 0;
    logic [7:0]  fuse_bits = 8'h6B;
    logic [15:0] z_addr = 0;
    logic [2:0]  fl_buf_idx = 0;
    logic [7:0]  cmd_rdata, lpm_data, lock_bits;
    logic        lpm_valid, fl_req, fl_op, rww_busy, cpu_halt;
    logic [11:0] fl_page;
    logic [15:0] fl_buf_word;

    always #4 clk = ~clk;   // 125 MHz

    flash_selfprog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
        .z_addr(z_addr), .data_lo(data_lo), .data_hi(data_hi),
        .fuse_bits(fuse_bits), .lpm_valid(lpm_valid), .lpm_data(lpm_data),
        .lock_bits(lock_bits), .fl_req(fl_req), .fl_op(fl_op), .fl_page(fl_page),
        .fl_done(fl_done), .fl_buf_idx(fl_buf_idx), .fl_buf_word(fl_buf_word),
        .rww_busy(rww_busy), .cpu_halt(cpu_halt)
    );

    int    checks = 0, errors = 0;
    bit    done_flag = 0;
    string cur = "R1";

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st, m_age, m_cmd, m_page, c;
    bit          m_rww, m_halt, m_op, m_loaded, m_lpm_v;
    logic [7:0]  m_lock, m_lpm_d;
    logic [15:0] m_buf [8];

    function automatic int m_decode(input logic [7:0] b);
        if (b[1]) return 2;
        if (b[2]) return 3;
        if (b[3]) return 4;
        if (b[4]) return 5;
        if (b[5]) return 6;
        return 1;
    endfunction

    function automatic logic [7:0] m_sig(input logic [1:0] i);
        case (i)
            2'd0: return 8'h1E;
            2'd1: return 8'h3C;
            2'd2: return 8'h5A;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int m_status();
        int s;
        s = (m_st != 0) ? 1 : 0;
        if (m_cmd >= 2) s = s | (1 << (m_cmd - 1));
        if (m_rww) s = s | 8'h40;
        return s;
    endfunction

    task automatic m_fill();
        for (int i = 0; i < 8; i++) m_buf[i] = 16'hFFFF;
        m_loaded = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_age = 0; m_cmd = 0; m_rww = 0; m_halt = 0; m_op = 0;
            m_page = 0; m_lock = 8'hFF; m_lpm_v = 0; m_lpm_d = 0;
            m_fill();
        end else begin
            m_lpm_v = 0;
            if (m_st == 2) begin
                if (fl_done) begin
                    if (m_cmd == 3) m_fill();
                    m_halt = 0; m_st = 0; m_cmd = 0;
                end
            end else if (cmd_we) begin
                if (cmd_wdata[0] && cmd_wdata[7:6] == 2'b00) begin
                    c = m_decode(cmd_wdata);
                    if (c == 5 && m_loaded) m_fill();
                    m_st = 1; m_age = 0; m_cmd = c;
                end else begin
                    m_st = 0; m_cmd = 0;
                end
            end else if (m_st == 1) begin
                if (lpm_strobe && m_age < 3 && (m_cmd == 4 || m_cmd == 6)) begin
                    m_lpm_v = 1;
                    m_lpm_d = (m_cmd == 6) ? m_sig(z_addr[1:0]) : (z_addr[0] ? fuse_bits : m_lock);
                end
                if (spm_strobe && m_cmd != 6) begin
                    case (m_cmd)
                        1: begin m_buf[z_addr[3:1]] = {data_hi, data_lo}; m_loaded = 1; end
                        2, 3: begin
                            m_op = (m_cmd == 3); m_page = int'(z_addr) / 16;
                            if (m_page >= 3584) m_halt = 1; else m_rww = 1;
                        end
                        4: m_lock = data_lo;
                        5: m_rww = 0;
                        default: ;
                    endcase
                    if (m_cmd == 2 || m_cmd == 3) m_st = 2;
                    else begin m_st = 0; m_cmd = 0; end
                end else begin
                    m_age++;
                    if (m_age == 4) begin m_st = 0; m_cmd = 0; end
                end
            end
        end
    end

    // cycle-by-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done_flag) begin
            cmp(cur, "status", cmd_rdata, m_status());
            cmp(cur, "fl_req", fl_req, m_st == 2);
            if (fl_req) begin
                cmp(cur, "fl_op", fl_op, m_op);
                cmp(cur, "fl_page", fl_page, m_page);
            end
            cmp(cur, "cpu_halt", cpu_halt, m_halt);
            cmp(cur, "rww_busy", rww_busy, m_rww);
            cmp(cur, "lock_bits", lock_bits, m_lock);
            cmp(cur, "lpm_valid", lpm_valid, m_lpm_v);
            if (lpm_valid) cmp(cur, "lpm_data", lpm_data, m_lpm_d);
            cmp(cur, "buf_word", fl_buf_word, m_buf[fl_buf_idx]);
        end
    end

    // flash array responder: done pulse six cycles into a request
    int lat = 0;
    always @(negedge clk) begin
        if (fl_done) fl_done <= 1'b0;
        else if (fl_req) begin
            if (lat == 5) begin fl_done <= 1'b1; lat = 0; end
            else lat++;
        end
    end

    // ---------------- stimulus tasks (start and end at a falling edge) ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [7:0] b);
        cmd_we = 1; cmd_wdata = b;
        @(negedge clk);
        cmd_we = 0; cmd_wdata = 0;
    endtask

    task automatic spm(input logic [15:0] z, input logic [7:0] hi, input logic [7:0] lo);
        spm_strobe = 1; z_addr = z; data_hi = hi; data_lo = lo;
        @(negedge clk);
        spm_strobe = 0;
    endtask

    task automatic lpm(input logic [15:0] z);
        lpm_strobe = 1; z_addr = z;
        @(negedge clk);
        lpm_strobe = 0;
    endtask

    task automatic peek(input int idx, input string tag, input int exp);
        fl_buf_idx = idx[2:0];
        #1;
        cmp(tag, "buffer word", fl_buf_word, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20 && fl_req; i++) @(negedge clk);
        idle(1);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        cur = "R1";
        cmp("R1", "status", cmd_rdata, 0);
        cmp("R1", "lock", lock_bits, 8'hFF);
        cmp("R1", "req/halt/busy/valid", {fl_req, cpu_halt, rww_busy, lpm_valid}, 0);
        idle(1);

        // R3: word load, z bit 0 ignored
        cur = "R3";
        arm(8'h01);
        #1 cmp("R2", "status armed", cmd_rdata, 8'h01);
        spm(16'h0005, 8'hA5, 8'h5A);
        #1 cmp("R3", "status cleared", cmd_rdata, 0);
        peek(2, "R3", 16'hA55A);
        peek(0, "R3", 16'hFFFF);
        idle(1);

        // R2: strobe on the fourth edge, then expiry, then disarm
        cur = "R2";
        arm(8'h01); idle(3);
        spm(16'h000E, 8'hB0, 8'h0C);
        peek(7, "R2", 16'hB00C);
        idle(1);
        arm(8'h01); idle(3);
        #1 cmp("R2", "status before expiry", cmd_rdata, 8'h01);
        idle(1);
        #1 cmp("R2", "status after expiry", cmd_rdata, 0);
        spm(16'h0002, 8'h12, 8'h34);
        peek(1, "R2", 16'hFFFF);
        arm(8'h01); arm(8'h00);
        #1 cmp("R2", "disarm", cmd_rdata, 0);
        arm(8'h41);
        #1 cmp("R2", "reserved bit blocks arm", cmd_rdata, 0);
        idle(2);

        // R10: re-enable arming drops loaded words
        cur = "R10";
        arm(8'h11);
        peek(2, "R10", 16'hFFFF);
        peek(7, "R10", 16'hFFFF);
        idle(5);

        // R5 / R6 / R7: program an RWW page
        cur = "R5";
        arm(8'h01); spm(16'h0000, 8'h11, 8'h11);
        arm(8'h01); spm(16'h0006, 8'h33, 8'h33);
        arm(8'h05); spm(16'h0050, 8'hDE, 8'hAD);
        #1;
        cmp("R5", "req/op", {fl_req, fl_op}, 2'b11);
        cmp("R5", "page", fl_page, 5);
        cmp("R7", "rww_busy", rww_busy, 1);
        cmp("R8", "no halt for rww page", cpu_halt, 0);
        cur = "R6";
        arm(8'h03);
        #1 cmp("R6", "write ignored while busy", cmd_rdata, 8'h45);
        fl_buf_idx = 3;
        wait_done();
        #1 cmp("R6", "status after done", cmd_rdata, 8'h40);
        cmp("R6", "req dropped", fl_req, 0);
        peek(3, "R5", 16'hFFFF);
        peek(0, "R5", 16'hFFFF);

        // R9: release the section
        cur = "R9";
        arm(8'h11); spm(16'h0000, 8'h00, 8'h00);
        #1 cmp("R9", "rww_busy cleared", rww_busy, 0);
        cmp("R9", "status", cmd_rdata, 0);
        idle(1);

        // R4 / R8: erase an NRWW page
        cur = "R4";
        arm(8'h03); spm(16'd57600, 8'h99, 8'h88);
        #1;
        cmp("R4", "req/op", {fl_req, fl_op}, 2'b10);
        cmp("R4", "page", fl_page, 3600);
        cmp("R8", "halt", cpu_halt, 1);
        cmp("R7", "no rww busy", rww_busy, 0);
        cur = "R8";
        wait_done();
        #1 cmp("R8", "halt released", cpu_halt, 0);
        idle(1);

        // R11: lock set
        cur = "R11";
        arm(8'h09); spm(16'hFFFF, 8'h77, 8'hC3);
        #1 cmp("R11", "lock", lock_bits, 8'hC3);
        idle(1);

        // R12: read modes
        cur = "R12";
        arm(8'h09); lpm(16'h0000);
        #1 cmp("R12", "lock read", {lpm_valid, lpm_data}, {1'b1, 8'hC3});
        idle(5);
        arm(8'h09); idle(2); lpm(16'h0001);
        #1 cmp("R12", "fuse read third edge", {lpm_valid, lpm_data}, {1'b1, 8'h6B});
        idle(5);
        arm(8'h09); idle(3); lpm(16'h0001);
        #1 cmp("R12", "fourth edge not served", lpm_valid, 0);
        idle(2);
        arm(8'h21); lpm(16'h0001);
        #1 cmp("R12", "signature byte 1", {lpm_valid, lpm_data}, {1'b1, 8'h3C});
        idle(5);
        arm(8'h21); lpm(16'h0003);
        #1 cmp("R12", "signature byte 3", {lpm_valid, lpm_data}, {1'b1, 8'hFF});
        idle(5);
        arm(8'h21); spm(16'h0000, 8'h00, 8'h00);
        #1 cmp("R12", "store under signature", {cmd_rdata, lock_bits}, {8'h21, 8'hC3});
        idle(5);

        // R13: priority
        cur = "R13";
        arm(8'h3F);
        #1 cmp("R13", "erase wins", cmd_rdata, 8'h03);
        arm(8'h1D);
        #1 cmp("R13", "program over lock", cmd_rdata, 8'h05);
        arm(8'h39);
        #1 cmp("R13", "lock over re-enable", cmd_rdata, 8'h09);
        spm(16'h0010, 8'h00, 8'hF0);
        #1 cmp("R13", "lock executed", lock_bits, 8'hF0);
        idle(2);

        finish_run();
    end
endmodule